// File: doc/BRIEF.md
# MEI Snoop Coherency Controller

This block keeps the coherency state of a small direct-mapped set of data-cache lines. It follows a three-state protocol: Modified, Exclusive and Invalid. There is no shared state. The processor side presents load and store requests by line address. The bus side presents snooped transactions, each with a 5-bit transfer type. For every request the controller works out whether the bus needs a write-back, a line fill or no action at all. It then commits the line's new state.

Every line fill goes out as a read-with-intent-to-modify, so this cache always ends up as the only holder of a filled line. A snooped global transfer removes a matching line, and a Modified line is written back first. A caching-inhibited read is the exception: it leaves the line resident and only cleans it. Write-backs and fills are issued on a single request channel with a valid/ready handshake. A line's state changes only in the cycle the bus accepts the request.

Top module: `mei_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req_valid` and `cpu_ack` are low, and `snp_ready` is high. A first load to any address therefore needs a fill.
- R2: A load miss and a store miss each issue exactly one request with `bus_req_kind`=1 (read-with-intent-to-modify) for the requested line address. When the request is accepted the line becomes Exclusive and the access is acknowledged.
- R3: A store that hits an Exclusive line is acknowledged with no bus request, and the line becomes Modified.
- R4: A load that hits an Exclusive or Modified line is acknowledged in the cycle it is presented, with no bus request and no change of state.
- R5: A snooped transfer that is not a caching-inhibited read and hits a Modified line issues one request with `bus_req_kind`=0 (write-back) for that line. When the request is accepted the line becomes Invalid.
- R6: A snooped transfer that is not a caching-inhibited read and hits an Exclusive line makes the line Invalid with no bus request.
- R7: A snooped transfer whose type has bits [3:0] equal to 4'b1010 is a caching-inhibited read, and bit 4 is ignored. On a Modified line it causes a write-back, after which the line is Exclusive. On an Exclusive line it causes no request and the line stays Exclusive.
- R8: A snoop whose tag does not match the indexed line, or whose line is Invalid, causes no bus request and leaves the line's state unchanged.
- R9: A miss whose indexed victim is Modified first issues a write-back of the victim's line address. Only after that request is accepted does it issue the fill for the new line. A victim that is not Modified is replaced with no write-back.
- R10: When a snoop and a processor access arrive in the same cycle, the snoop is taken first and `cpu_ack` stays low in that cycle. The processor access is then evaluated against the state the snoop left.
- R11: While `bus_req_valid` is high and `bus_req_ready` is low, the request's address and kind stay unchanged, and the access that caused it is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access present; held until `cpu_ack` |
| cpu_store | input | 1 | 1 = store, 0 = load |
| cpu_line | input | TAG_W+IDX_W | Processor line address (tag above index) |
| cpu_ack | output | 1 | Processor access completed this cycle |
| snp_valid | input | 1 | Snooped global transfer present |
| snp_line | input | TAG_W+IDX_W | Snooped line address |
| snp_tt | input | TT_W | Snooped transfer type |
| snp_ready | output | 1 | Snoop accepted this cycle |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_kind | output | 1 | 0 = write-back, 1 = read-with-intent-to-modify |
| bus_req_line | output | TAG_W+IDX_W | Line address of the request |
| bus_req_ready | input | 1 | Bus accepts the pending request |

## Verification
The bench builds the block with its defaults: four lines, a 10-bit tag, a 5-bit transfer type and caching-inhibited reads preserved. With four lines, two tags can be made to collide on index 0 while indices 1 to 3 carry independent lines, so evictions of clean and dirty victims can be provoked next to lines that are left alone. The transfer types include caching-inhibited codes with bit 4 both clear and set, as well as ordinary reads and writes. Some cases delay the bus ready for several cycles to expose when the state commits.

// File: rtl/mei_pkg.sv
package mei_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_EXC = 2'd1,
      LS_MOD = 2'd2
   } lstate_e;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_SNPWB = 2'd1,
      FS_VICWB = 2'd2,
      FS_FILL  = 2'd3
   } fsm_e;

   localparam logic BK_WB    = 1'b0;
   localparam logic BK_RWITM = 1'b1;
endpackage

// File: rtl/mei_line_store.sv
module mei_line_store
   import mei_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int TAG_W     = 10,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rda_idx,
   output logic [TAG_W-1:0] rda_tag,
   output lstate_e          rda_st,
   input  logic [IDX_W-1:0] rdb_idx,
   output logic [TAG_W-1:0] rdb_tag,
   output lstate_e          rdb_st,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  lstate_e          wr_st
);
   logic [TAG_W-1:0] tag_q [NUM_LINES];
   lstate_e          st_q  [NUM_LINES];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic [TAG_W-1:0] tag_r;
      lstate_e          st_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_r <= '0;
            st_r  <= LS_INV;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            tag_r <= wr_tag;
            st_r  <= wr_st;
         end
      end
      assign tag_q[g] = tag_r;
      assign st_q[g]  = st_r;
   end

   assign rda_tag = tag_q[rda_idx];
   assign rda_st  = st_q[rda_idx];
   assign rdb_tag = tag_q[rdb_idx];
   assign rdb_st  = st_q[rdb_idx];

   // R3: a line can only become Modified from a resident state
   assert_modify_resident_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_st == LS_MOD) |-> (st_q[wr_idx] != LS_INV));
endmodule

// File: rtl/mei_snoop_eval.sv
module mei_snoop_eval
   import mei_pkg::*;
#(
   parameter int          TT_W        = 5,
   parameter bit          CI_PRESERVE = 1'b1,
   parameter logic [TT_W-2:0] CI_CODE = 4'b1010
) (
   input  logic [TT_W-1:0] tt,
   input  logic            hit,
   input  lstate_e         cur_st,
   output logic            need_wb,
   output logic            change,
   output lstate_e         next_st
);
   logic is_ci;

   if (CI_PRESERVE) begin : g_ci_keep
      logic unused_tt_top;
      assign unused_tt_top = tt[TT_W-1];
      assign is_ci = (tt[TT_W-2:0] == CI_CODE);
   end else begin : g_ci_flush
      logic unused_tt_all;
      assign unused_tt_all = ^tt;
      assign is_ci = 1'b0;
   end

   always_comb begin
      need_wb = 1'b0;
      change  = 1'b0;
      next_st = cur_st;
      if (hit) begin
         if (cur_st == LS_MOD) begin
            need_wb = 1'b1;
            change  = 1'b1;
            next_st = is_ci ? LS_EXC : LS_INV;
         end else if (cur_st == LS_EXC && !is_ci) begin
            change  = 1'b1;
            next_st = LS_INV;
         end
      end
   end
endmodule

// File: rtl/mei_coh_ctrl.sv
module mei_coh_ctrl
   import mei_pkg::*;
#(
   parameter int  NUM_LINES   = 4,
   parameter int  TAG_W       = 10,
   parameter int  TT_W        = 5,
   parameter bit  CI_PRESERVE = 1'b1,
   localparam int IDX_W       = $clog2(NUM_LINES),
   localparam int LA_W        = TAG_W + IDX_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_valid,
   input  logic            cpu_store,
   input  logic [LA_W-1:0] cpu_line,
   output logic            cpu_ack,
   input  logic            snp_valid,
   input  logic [LA_W-1:0] snp_line,
   input  logic [TT_W-1:0] snp_tt,
   output logic            snp_ready,
   output logic            bus_req_valid,
   output logic            bus_req_kind,
   output logic [LA_W-1:0] bus_req_line,
   input  logic            bus_req_ready
);
   initial begin
      if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES)
         $fatal(1, "NUM_LINES must be a power of two of at least 2");
      if (TAG_W < 1)
         $fatal(1, "TAG_W must be positive");
      if (TT_W < 5)
         $fatal(1, "TT_W must be at least 5");
   end

   fsm_e            fsm_q, fsm_d;
   logic [LA_W-1:0] pend_q, pend_d;
   logic [LA_W-1:0] fill_q, fill_d;
   lstate_e         pst_q, pst_d;

   logic [IDX_W-1:0] cpu_idx, snp_idx, pend_idx;
   logic [TAG_W-1:0] cpu_tag, snp_tag, pend_tag;
   assign cpu_idx  = cpu_line[IDX_W-1:0];
   assign cpu_tag  = cpu_line[LA_W-1:IDX_W];
   assign snp_idx  = snp_line[IDX_W-1:0];
   assign snp_tag  = snp_line[LA_W-1:IDX_W];
   assign pend_idx = pend_q[IDX_W-1:0];
   assign pend_tag = pend_q[LA_W-1:IDX_W];

   logic [TAG_W-1:0] tag_a, tag_b, wr_tag;
   lstate_e          st_a, st_b, wr_st;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;

   mei_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rda_idx (cpu_idx),
      .rda_tag (tag_a),
      .rda_st  (st_a),
      .rdb_idx (snp_idx),
      .rdb_tag (tag_b),
      .rdb_st  (st_b),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_tag  (wr_tag),
      .wr_st   (wr_st)
   );

   logic cpu_hit, snp_hit;
   assign cpu_hit = (st_a != LS_INV) && (tag_a == cpu_tag);
   assign snp_hit = (st_b != LS_INV) && (tag_b == snp_tag);

   logic    sn_wb, sn_change;
   lstate_e sn_next;

   mei_snoop_eval #(.TT_W(TT_W), .CI_PRESERVE(CI_PRESERVE)) u_eval (
      .tt      (snp_tt),
      .hit     (snp_hit),
      .cur_st  (st_b),
      .need_wb (sn_wb),
      .change  (sn_change),
      .next_st (sn_next)
   );

   always_comb begin
      fsm_d   = fsm_q;
      pend_d  = pend_q;
      fill_d  = fill_q;
      pst_d   = pst_q;
      wr_en   = 1'b0;
      wr_idx  = cpu_idx;
      wr_tag  = tag_a;
      wr_st   = st_a;
      cpu_ack = 1'b0;
      unique case (fsm_q)
         FS_IDLE: begin
            if (snp_valid) begin
               if (sn_wb) begin
                  fsm_d  = FS_SNPWB;
                  pend_d = {tag_b, snp_idx};
                  pst_d  = sn_next;
               end else if (sn_change) begin
                  wr_en  = 1'b1;
                  wr_idx = snp_idx;
                  wr_tag = tag_b;
                  wr_st  = sn_next;
               end
            end else if (cpu_valid) begin
               if (cpu_hit) begin
                  cpu_ack = 1'b1;
                  if (cpu_store && st_a != LS_MOD) begin
                     wr_en = 1'b1;
                     wr_st = LS_MOD;
                  end
               end else begin
                  fill_d = cpu_line;
                  if (st_a == LS_MOD) begin
                     fsm_d  = FS_VICWB;
                     pend_d = {tag_a, cpu_idx};
                  end else begin
                     fsm_d  = FS_FILL;
                     pend_d = cpu_line;
                  end
               end
            end
         end
         FS_SNPWB: begin
            if (bus_req_ready) begin
               wr_en  = 1'b1;
               wr_idx = pend_idx;
               wr_tag = pend_tag;
               wr_st  = pst_q;
               fsm_d  = FS_IDLE;
            end
         end
         FS_VICWB: begin
            if (bus_req_ready) begin
               pend_d = fill_q;
               fsm_d  = FS_FILL;
            end
         end
         FS_FILL: begin
            if (bus_req_ready) begin
               wr_en  = 1'b1;
               wr_idx = pend_idx;
               wr_tag = pend_tag;
               wr_st  = LS_EXC;
               fsm_d  = FS_IDLE;
            end
         end
         default: fsm_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q  <= FS_IDLE;
         pend_q <= '0;
         fill_q <= '0;
         pst_q  <= LS_INV;
      end else begin
         fsm_q  <= fsm_d;
         pend_q <= pend_d;
         fill_q <= fill_d;
         pst_q  <= pst_d;
      end
   end

   assign snp_ready     = (fsm_q == FS_IDLE);
   assign bus_req_valid = (fsm_q != FS_IDLE);
   assign bus_req_kind  = (fsm_q == FS_FILL) ? BK_RWITM : BK_WB;
   assign bus_req_line  = pend_q;

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_req_ready) |=>
         (bus_req_valid && $stable(bus_req_line) && $stable(bus_req_kind)));

   assert_ack_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> !bus_req_valid);

   assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_ready) |-> !cpu_ack);

   assert_fill_after_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_q == FS_VICWB && bus_req_ready) |=>
         (bus_req_valid && bus_req_kind == BK_RWITM));
endmodule

// File: tb/mei_coh_ctrl_tb.sv
module mei_coh_ctrl_tb;
   localparam int LA_W = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cpu_valid = 1'b0, cpu_store = 1'b0;
   logic [LA_W-1:0] cpu_line = '0;
   logic            cpu_ack;
   logic            snp_valid = 1'b0;
   logic [LA_W-1:0] snp_line = '0;
   logic [4:0]      snp_tt = '0;
   logic            snp_ready;
   logic            bus_req_valid, bus_req_kind;
   logic [LA_W-1:0] bus_req_line;
   logic            bus_req_ready = 1'b0;

   mei_coh_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_store(cpu_store), .cpu_line(cpu_line), .cpu_ack(cpu_ack),
      .snp_valid(snp_valid), .snp_line(snp_line), .snp_tt(snp_tt), .snp_ready(snp_ready),
      .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
      .bus_req_line(bus_req_line), .bus_req_ready(bus_req_ready)
   );

   always #10 clk = ~clk;

   localparam logic [LA_W-1:0] LA = 12'h010, LB = 12'h020, LC = 12'h011,
                               LD = 12'h012, LE = 12'h013;
   localparam logic [4:0] TT_RD = 5'b01110, TT_WR = 5'b00010,
                          TT_CI0 = 5'b01010, TT_CI1 = 5'b11010;

   int checks = 0, errors = 0, ready_delay = 0;
   int nev;
   logic            ev_kind [4];
   logic [LA_W-1:0] ev_line [4];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic record();
      if (nev < 4) begin
         ev_kind[nev] = bus_req_kind;
         ev_line[nev] = bus_req_line;
      end
      nev++;
   endtask

   task automatic expect_ev(input string req, input int n,
                            input logic k0, input logic [LA_W-1:0] a0,
                            input logic k1, input logic [LA_W-1:0] a1);
      chk(nev == n, req, "bus request count", nev, n);
      if (n >= 1 && nev >= 1)
         chk(ev_kind[0] == k0 && ev_line[0] == a0, req, "first request",
             {ev_kind[0], ev_line[0]}, {k0, a0});
      if (n >= 2 && nev >= 2)
         chk(ev_kind[1] == k1 && ev_line[1] == a1, req, "second request",
             {ev_kind[1], ev_line[1]}, {k1, a1});
   endtask

   // entered at a negedge with inputs already driven
   task automatic run_cpu(input string req);
      bit pend = 0;
      int stall = 0;
      bit acked = 0;
      for (int i = 0; i < 40 && !acked; i++) begin
         #1;
         if (cpu_ack) begin
            if (pend) chk(0, req, "ack while request stalled", 1, 0);
            acked = 1;
         end else if (bus_req_valid) begin
            if (!pend) begin
               record();
               pend  = 1;
               stall = 0;
            end else begin
               chk(bus_req_kind == ev_kind[nev-1] && bus_req_line == ev_line[nev-1],
                   "R11", "stalled request stable",
                   {bus_req_kind, bus_req_line}, {ev_kind[nev-1], ev_line[nev-1]});
            end
            if (stall >= ready_delay) begin
               bus_req_ready = 1'b1;
               pend = 0;
            end else begin
               stall++;
            end
         end
         @(negedge clk);
         bus_req_ready = 1'b0;
      end
      cpu_valid = 1'b0;
      chk(acked, req, "processor access acknowledged", acked, 1);
   endtask

   task automatic drain_bus();
      for (int i = 0; i < 10; i++) begin
         #1;
         if (!bus_req_valid) break;
         record();
         bus_req_ready = 1'b1;
         @(negedge clk);
         bus_req_ready = 1'b0;
      end
   endtask

   task automatic cpu_op(input bit st, input logic [LA_W-1:0] line, input string req,
                         input int n, input logic k0, input logic [LA_W-1:0] a0,
                         input logic k1, input logic [LA_W-1:0] a1);
      nev = 0;
      @(negedge clk);
      cpu_valid = 1'b1;
      cpu_store = st;
      cpu_line  = line;
      run_cpu(req);
      expect_ev(req, n, k0, a0, k1, a1);
   endtask

   task automatic snoop_op(input logic [LA_W-1:0] line, input logic [4:0] tt,
                           input string req, input int n);
      nev = 0;
      @(negedge clk);
      snp_valid = 1'b1;
      snp_line  = line;
      snp_tt    = tt;
      #1 chk(snp_ready, req, "snoop accepted", snp_ready, 1);
      @(negedge clk);
      snp_valid = 1'b0;
      drain_bus();
      expect_ev(req, n, 1'b0, line, 1'b0, line);
   endtask

   task automatic t_reset();
      @(negedge clk);
      #1;
      chk(!bus_req_valid, "R1", "bus_req_valid after reset", bus_req_valid, 0);
      chk(!cpu_ack, "R1", "cpu_ack after reset", cpu_ack, 0);
      chk(snp_ready, "R1", "snp_ready after reset", snp_ready, 1);
      cpu_op(0, LE, "R1", 1, 1'b1, LE, 1'b0, '0);
   endtask

   task automatic t_load_miss();
      cpu_op(0, LA, "R2", 1, 1'b1, LA, 1'b0, '0);
      cpu_op(0, LA, "R4", 0, 1'b0, '0, 1'b0, '0);
   endtask

   task automatic t_store_and_snoop_mod();
      cpu_op(1, LA, "R3", 0, 1'b0, '0, 1'b0, '0);
      cpu_op(0, LA, "R4", 0, 1'b0, '0, 1'b0, '0);
      snoop_op(LA, TT_RD, "R5", 1);
      cpu_op(0, LA, "R5", 1, 1'b1, LA, 1'b0, '0);
   endtask

   task automatic t_store_miss();
      cpu_op(1, LC, "R2", 1, 1'b1, LC, 1'b0, '0);
      snoop_op(LC, TT_WR, "R5", 1);
      cpu_op(0, LC, "R2", 1, 1'b1, LC, 1'b0, '0);
   endtask

   task automatic t_snoop_exc();
      snoop_op(LC, TT_WR, "R6", 0);
      cpu_op(0, LC, "R6", 1, 1'b1, LC, 1'b0, '0);
   endtask

   task automatic t_ci_read();
      cpu_op(1, LD, "R7", 1, 1'b1, LD, 1'b0, '0);
      snoop_op(LD, TT_CI1, "R7", 1);
      cpu_op(0, LD, "R7", 0, 1'b0, '0, 1'b0, '0);
      snoop_op(LD, TT_CI0, "R7", 0);
      cpu_op(0, LD, "R7", 0, 1'b0, '0, 1'b0, '0);
      snoop_op(LD, TT_RD, "R6", 0);
      cpu_op(0, LD, "R6", 1, 1'b1, LD, 1'b0, '0);
   endtask

   task automatic t_snoop_miss();
      snoop_op(LB, TT_RD, "R8", 0);
      cpu_op(0, LA, "R8", 0, 1'b0, '0, 1'b0, '0);
      snoop_op(12'h053, TT_WR, "R8", 0);
      cpu_op(0, LE, "R8", 0, 1'b0, '0, 1'b0, '0);
   endtask

   task automatic t_evict();
      cpu_op(1, LA, "R3", 0, 1'b0, '0, 1'b0, '0);
      cpu_op(0, LB, "R9", 2, 1'b0, LA, 1'b1, LB);
      cpu_op(0, LA, "R9", 1, 1'b1, LA, 1'b0, '0);
   endtask

   task automatic t_same_cycle();
      cpu_op(1, LA, "R3", 0, 1'b0, '0, 1'b0, '0);
      nev = 0;
      @(negedge clk);
      snp_valid = 1'b1; snp_line = LA; snp_tt = TT_RD;
      cpu_valid = 1'b1; cpu_store = 1'b0; cpu_line = LA;
      #1 chk(!cpu_ack, "R10", "no ack while snoop taken", cpu_ack, 0);
      @(negedge clk);
      snp_valid = 1'b0;
      run_cpu("R10");
      expect_ev("R10", 2, 1'b0, LA, 1'b1, LA);
   endtask

   task automatic t_handshake();
      snoop_op(LE, TT_WR, "R6", 0);
      ready_delay = 3;
      cpu_op(1, LE, "R11", 1, 1'b1, LE, 1'b0, '0);
      ready_delay = 0;
      snoop_op(LE, TT_RD, "R11", 1);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_miss();
      t_store_and_snoop_mod();
      t_store_miss();
      t_snoop_exc();
      t_ci_read();
      t_snoop_miss();
      t_evict();
      t_same_cycle();
      t_handshake();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule